// File: doc/BRIEF.md
# Block Pool Allocator

This block hands out regions of a 16384-byte buffer memory in whole blocks. It keeps one bit per block in a bitmap held in internal registers. With the default of two 32-bit map words the pool has 64 blocks of 256 bytes each. A client sends a request over a valid/ready handshake. An allocate request carries a byte size. The block then scans for a free, aligned run of blocks and answers with a byte offset, or with the failure code 16384. A free request carries an offset and a byte size and releases that run of blocks.

Allocation is first-fit. The block count of a request fixes a power-of-two stride, and every candidate start position is a multiple of that stride. A region therefore never straddles two map words. The scan tests one candidate position per clock cycle, so the time to answer shows how far the search had to go. A free takes one cycle and produces no response.

Top module: `blk_pool_alloc`

## Requirements
- R1: While reset is asserted and after it is released, req_ready is 1, rsp_valid is 0 and every block is free. Asserting reset again in mid-run frees every block.
- R2: A request size in bytes is turned into a block count by dividing by 256 and rounding up, for allocate and for free alike. For example, 257 bytes is 2 blocks and 700 bytes is 3 blocks.
- R3: A request with req_op=0 is an allocate. The scan covers map word 0 first, then word 1, and within a word it moves from bit 0 upward. It takes the first position whose whole run of blocks is free and marks those blocks as used, so they are not handed out again until freed. The offset returned is the block index times 256.
- R4: Candidate start positions step by a stride. The stride is the smallest of 1, 2, 4, 8, 16 or 32 blocks that is at least the block count, so a 3-block request only starts on multiples of 4 blocks.
- R5: An allocated region never spans two map words. A free whose run would pass the end of its word clears only the bits up to the end of that word.
- R6: An allocate answers with rsp_offset = 16384 when the size is 0, when the size is above 8192 bytes (more than 32 blocks), or when no aligned free run exists.
- R7: The scan tests one candidate per clock cycle, and req_ready is 0 while a scan runs. rsp_valid is a one-cycle pulse, and req_ready is 1 in that cycle. If candidate k (counted from 0) succeeds, the response is visible k+1 cycles after acceptance. If every candidate fails, the failure is visible after as many cycles as there are candidates. A zero or oversized request is answered in the cycle right after acceptance.
- R8: A request with req_op=1 is a free. It clears the run of blocks that starts at block offset/256, and the change is in effect in the cycle after acceptance. req_ready stays 1 and no response is produced.
- R9: A free is ignored when its offset is 16384 or more, or when its size is 0 or above 32 blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request (no scan running) |
| req_op | input | 1 | 0 = allocate, 1 = free |
| req_size | input | 16 | Request size in bytes |
| req_offset | input | 15 | Byte offset of the region to free |
| rsp_valid | output | 1 | One-cycle pulse when an allocate result is ready |
| rsp_offset | output | 15 | Allocated byte offset, or 16384 on failure |

## Verification
The allocate path is exercised with 1, 2, 3, 8, 16 and 32-block requests on a partly filled map. Each of these strides has to skip a different set of busy positions, so the returned offset shows whether alignment and first-fit order are right. The answer latency shows how many candidates were tested. Full-map scans with strides 1 and 2 are used to catch a bit that stays free or busy when it should not: one checks a lone free bit at the end of word 0, the other checks free runs that touch across the word boundary. Frees are tried with a rounded-up size, with a run that crosses the word end, with an offset outside the pool and with an oversized length. Each free is followed by an allocate that reveals exactly which bits changed.

// File: rtl/bpa_pkg.sv
package bpa_pkg;

   typedef enum logic {
      OP_ALLOC = 1'b0,
      OP_FREE  = 1'b1
   } bpa_op_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_SCAN = 1'b1
   } bpa_state_e;

endpackage

// File: rtl/bpa_size_decode.sv
// Turns a byte size into a block count, a validity flag and the log2 of
// the power-of-two scan stride.
module bpa_size_decode #(
   parameter int SIZE_W = 16,
   parameter int BLK_SH = 8,
   parameter int POS_W  = 5,
   localparam int LG_W  = $clog2(POS_W + 1)
) (
   input  logic [SIZE_W-1:0] size,
   output logic              ok,
   output logic [POS_W:0]    nblk,
   output logic [LG_W-1:0]   stride_lg
);

   localparam logic [SIZE_W:0] ROUND = (SIZE_W+1)'((1 << BLK_SH) - 1);
   localparam logic [SIZE_W:0] MAXB  = (SIZE_W+1)'(1 << POS_W);

   logic [SIZE_W:0] padded;
   logic [SIZE_W:0] blocks;

   assign padded = {1'b0, size} + ROUND;
   assign blocks = padded >> BLK_SH;
   assign ok     = (blocks != '0) && (blocks <= MAXB);
   assign nblk   = blocks[POS_W:0];

   // descending walk: the last hit is the smallest covering stride
   always_comb begin
      stride_lg = LG_W'(POS_W);
      for (int i = POS_W; i >= 0; i--) begin
         if (blocks <= (SIZE_W+1)'(1 << i)) stride_lg = LG_W'(i);
      end
   end

endmodule

// File: rtl/bpa_run_mask.sv
// Builds the in-word mask of a run of nblk bits starting at pos; bits
// past the word end fall away.
module bpa_run_mask #(
   parameter int WORD_BITS = 32,
   localparam int POS_W    = $clog2(WORD_BITS)
) (
   input  logic [POS_W:0]     nblk,
   input  logic [POS_W-1:0]   pos,
   output logic [WORD_BITS-1:0] mask
);

   logic [POS_W+1:0] lo;
   logic [POS_W+1:0] hi;

   assign lo = {2'b00, pos};
   assign hi = lo + {1'b0, nblk};

   for (genvar b = 0; b < WORD_BITS; b++) begin : g_bit
      assign mask[b] = ((POS_W+2)'(b) >= lo) && ((POS_W+2)'(b) < hi);
   end

endmodule

// File: rtl/bpa_map_regs.sv
// Occupancy bitmap: one bit per block, set by the scan, cleared by frees.
module bpa_map_regs #(
   parameter int WORD_BITS = 32,
   parameter int MAP_WORDS = 2,
   localparam int WIDX_W   = (MAP_WORDS > 1) ? $clog2(MAP_WORDS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_en,
   input  logic [WIDX_W-1:0]    set_word,
   input  logic [WORD_BITS-1:0] set_mask,
   input  logic                 clr_en,
   input  logic [WIDX_W-1:0]    clr_word,
   input  logic [WORD_BITS-1:0] clr_mask,
   output logic [WORD_BITS-1:0] map_q [MAP_WORDS]
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < MAP_WORDS; w++) map_q[w] <= '0;
      end else begin
         for (int w = 0; w < MAP_WORDS; w++) begin
            if (set_en && (set_word == WIDX_W'(w)))
               map_q[w] <= map_q[w] | set_mask;
            else if (clr_en && (clr_word == WIDX_W'(w)))
               map_q[w] <= map_q[w] & ~clr_mask;
         end
      end
   end

   // the scan only claims blocks that are currently free
   assert_set_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |-> ((map_q[set_word] & set_mask) == '0))
      else $error("claimed run overlaps used blocks");

   assert_set_applied_R3: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> ((map_q[$past(set_word)] & $past(set_mask)) == $past(set_mask)))
      else $error("claimed run not marked used");

   assert_clear_applied_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> ((map_q[$past(clr_word)] & $past(clr_mask)) == '0))
      else $error("freed run still marked used");

   assert_set_clr_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_en && clr_en))
      else $error("claim and free in the same cycle");

endmodule

// File: rtl/blk_pool_alloc.sv
module blk_pool_alloc
   import bpa_pkg::*;
#(
   parameter int POOL_BYTES = 16384,
   parameter int MAP_WORDS  = 2,
   parameter int WORD_BITS  = 32,
   parameter int SIZE_W     = 16,
   localparam int OFFS_W    = $clog2(POOL_BYTES) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_op,
   input  logic [SIZE_W-1:0] req_size,
   input  logic [OFFS_W-1:0] req_offset,
   output logic              rsp_valid,
   output logic [OFFS_W-1:0] rsp_offset
);

   localparam int NBLK      = MAP_WORDS * WORD_BITS;
   localparam int BLK_BYTES = POOL_BYTES / NBLK;
   localparam int BLK_SH    = $clog2(BLK_BYTES);
   localparam int POS_W     = $clog2(WORD_BITS);
   localparam int WIDX_W    = (MAP_WORDS > 1) ? $clog2(MAP_WORDS) : 1;
   localparam int LG_W      = $clog2(POS_W + 1);
   localparam int BIDX_W    = OFFS_W - BLK_SH;
   localparam logic [OFFS_W-1:0] FAIL_OFFS = OFFS_W'(POOL_BYTES);

   // elaboration-time parameter checks
   if ((1 << $clog2(POOL_BYTES)) != POOL_BYTES) begin : g_chk_pool
      $error("POOL_BYTES must be a power of two");
   end
   if ((1 << POS_W) != WORD_BITS) begin : g_chk_word
      $error("WORD_BITS must be a power of two");
   end
   if (MAP_WORDS < 1 || BLK_BYTES * NBLK != POOL_BYTES || BLK_BYTES < 2) begin : g_chk_split
      $error("pool must split into at least 2-byte blocks");
   end
   if (SIZE_W <= POS_W + BLK_SH) begin : g_chk_size
      $error("SIZE_W too narrow for a full-word request");
   end

   // ---------------- request decode ----------------
   logic            dec_ok;
   logic [POS_W:0]  dec_nblk;
   logic [LG_W-1:0] dec_lg;

   bpa_size_decode #(
      .SIZE_W (SIZE_W),
      .BLK_SH (BLK_SH),
      .POS_W  (POS_W)
   ) u_decode (
      .size      (req_size),
      .ok        (dec_ok),
      .nblk      (dec_nblk),
      .stride_lg (dec_lg)
   );

   bpa_state_e        state_q;
   logic [WIDX_W-1:0] word_q;
   logic [POS_W-1:0]  pos_q;
   logic [POS_W:0]    nblk_q;
   logic [LG_W-1:0]   lg_q;
   logic              rsp_valid_q;
   logic [OFFS_W-1:0] rsp_offset_q;

   logic accept, alloc_go, free_go;
   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign alloc_go  = accept && (req_op == OP_ALLOC);
   assign free_go   = accept && (req_op == OP_FREE);

   // ---------------- bitmap ----------------
   logic [WORD_BITS-1:0] map_w [MAP_WORDS];
   logic                 set_en, clr_en;
   logic [WORD_BITS-1:0] scan_mask, free_mask;
   logic [WIDX_W-1:0]    free_word;
   logic [POS_W-1:0]     free_pos;

   bpa_map_regs #(
      .WORD_BITS (WORD_BITS),
      .MAP_WORDS (MAP_WORDS)
   ) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (set_en),
      .set_word (word_q),
      .set_mask (scan_mask),
      .clr_en   (clr_en),
      .clr_word (free_word),
      .clr_mask (free_mask),
      .map_q    (map_w)
   );

   // ---------------- scan datapath ----------------
   bpa_run_mask #(.WORD_BITS(WORD_BITS)) u_scan_mask (
      .nblk (nblk_q),
      .pos  (pos_q),
      .mask (scan_mask)
   );

   logic              hit, wrap, last_word;
   logic [POS_W:0]    step, pos_nxt;
   logic [OFFS_W-1:0] hit_offs;

   assign hit       = (map_w[word_q] & scan_mask) == '0;
   assign step      = (POS_W+1)'(1) << lg_q;
   assign pos_nxt   = {1'b0, pos_q} + step;
   assign wrap      = pos_nxt[POS_W];
   assign last_word = (word_q == WIDX_W'(MAP_WORDS - 1));
   assign hit_offs  = OFFS_W'({word_q, pos_q}) << BLK_SH;
   assign set_en    = (state_q == ST_SCAN) && hit;

   // ---------------- free datapath ----------------
   logic [BIDX_W-1:0] free_idx;
   logic              free_in_pool;

   assign free_idx     = BIDX_W'(req_offset >> BLK_SH);
   assign free_in_pool = free_idx < BIDX_W'(NBLK);
   assign free_word    = WIDX_W'(free_idx >> POS_W);
   assign free_pos     = free_idx[POS_W-1:0];
   assign clr_en       = free_go && dec_ok && free_in_pool;

   bpa_run_mask #(.WORD_BITS(WORD_BITS)) u_free_mask (
      .nblk (dec_nblk),
      .pos  (free_pos),
      .mask (free_mask)
   );

   // ---------------- control ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         word_q       <= '0;
         pos_q        <= '0;
         nblk_q       <= '0;
         lg_q         <= '0;
         rsp_valid_q  <= 1'b0;
         rsp_offset_q <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (alloc_go) begin
                  if (dec_ok) begin
                     state_q <= ST_SCAN;
                     word_q  <= '0;
                     pos_q   <= '0;
                     nblk_q  <= dec_nblk;
                     lg_q    <= dec_lg;
                  end else begin
                     rsp_valid_q  <= 1'b1;
                     rsp_offset_q <= FAIL_OFFS;
                  end
               end
            end
            ST_SCAN: begin
               if (hit) begin
                  state_q      <= ST_IDLE;
                  rsp_valid_q  <= 1'b1;
                  rsp_offset_q <= hit_offs;
               end else if (wrap) begin
                  if (last_word) begin
                     state_q      <= ST_IDLE;
                     rsp_valid_q  <= 1'b1;
                     rsp_offset_q <= FAIL_OFFS;
                  end else begin
                     word_q <= word_q + WIDX_W'(1);
                     pos_q  <= '0;
                  end
               end else begin
                  pos_q <= pos_nxt[POS_W-1:0];
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rsp_valid  = rsp_valid_q;
   assign rsp_offset = rsp_offset_q;

   // ---------------- assertions ----------------
   assert_rsp_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_q |-> (state_q == ST_IDLE))
      else $error("response while a scan is still running");

   assert_offset_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid_q && (rsp_offset_q != FAIL_OFFS)) |->
         ((rsp_offset_q[BLK_SH-1:0] == '0) &&
          (((rsp_offset_q >> BLK_SH) & ((OFFS_W'(1) << lg_q) - OFFS_W'(1))) == '0)))
      else $error("offset not aligned to its stride");

   assert_fail_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_q |-> (rsp_offset_q <= FAIL_OFFS))
      else $error("offset beyond the failure code");

endmodule

// File: tb/blk_pool_alloc_tb.sv
`timescale 1ns/1ps
module blk_pool_alloc_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_op = 1'b0;
   logic [15:0] req_size = '0;
   logic [14:0] req_offset = '0;
   logic        rsp_valid;
   logic [14:0] rsp_offset;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   blk_pool_alloc dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_op     (req_op),
      .req_size   (req_size),
      .req_offset (req_offset),
      .rsp_valid  (rsp_valid),
      .rsp_offset (rsp_offset)
   );

   localparam int FAILV = 16384;

   // entry: {op, size[16], offset[15], expected offset[15], latency[8], req[4]}
   localparam int NV = 28;
   localparam logic [58:0] VEC [NV] = '{
      {1'b0, 16'd256,   15'd0,     15'd0,     8'd1,  4'd3}, // R3 empty map, bit 0
      {1'b0, 16'd257,   15'd0,     15'd512,   8'd2,  4'd2}, // R2 257 B -> 2 blocks
      {1'b0, 16'd700,   15'd0,     15'd1024,  8'd2,  4'd4}, // R4 3 blocks, stride 4
      {1'b0, 16'd256,   15'd0,     15'd256,   8'd2,  4'd3}, // R3 first fit fills bit 1
      {1'b0, 16'd8192,  15'd0,     15'd8192,  8'd2,  4'd4}, // R4 stride 32, word 1
      {1'b0, 16'd4096,  15'd0,     15'd4096,  8'd2,  4'd4}, // R4 stride 16
      {1'b0, 16'd2048,  15'd0,     15'd2048,  8'd2,  4'd4}, // R4 stride 8
      {1'b0, 16'd512,   15'd0,     15'd16384, 8'd32, 4'd6}, // R6 lone free bit 7
      {1'b0, 16'd256,   15'd0,     15'd1792,  8'd8,  4'd7}, // R7 eighth candidate
      {1'b1, 16'd256,   15'd20000, 15'd0,     8'd0,  4'd9}, // R9 offset outside pool
      {1'b0, 16'd256,   15'd0,     15'd16384, 8'd64, 4'd9}, // R9 nothing was freed
      {1'b1, 16'd8448,  15'd0,     15'd0,     8'd0,  4'd9}, // R9 33 blocks
      {1'b0, 16'd256,   15'd0,     15'd16384, 8'd64, 4'd9}, // R9 nothing was freed
      {1'b0, 16'd0,     15'd0,     15'd16384, 8'd0,  4'd6}, // R6 zero size
      {1'b0, 16'd8193,  15'd0,     15'd16384, 8'd0,  4'd6}, // R6 above 32 blocks
      {1'b1, 16'd8192,  15'd8192,  15'd0,     8'd0,  4'd8}, // R8 free word 1
      {1'b0, 16'd8192,  15'd0,     15'd8192,  8'd2,  4'd8}, // R8 reuse
      {1'b1, 16'd2048,  15'd6144,  15'd0,     8'd0,  4'd8}, // R8 bits 24..31
      {1'b1, 16'd2048,  15'd8192,  15'd0,     8'd0,  4'd8}, // R8 bits 32..39
      {1'b0, 16'd4096,  15'd0,     15'd16384, 8'd4,  4'd5}, // R5 no cross-word run
      {1'b0, 16'd2048,  15'd0,     15'd6144,  8'd4,  4'd5}, // R5 top of word 0
      {1'b0, 16'd2048,  15'd0,     15'd8192,  8'd5,  4'd5}, // R5 bottom of word 1
      {1'b1, 16'd512,   15'd7936,  15'd0,     8'd0,  4'd5}, // R5 free cut at word end
      {1'b0, 16'd512,   15'd0,     15'd16384, 8'd32, 4'd5}, // R5 only bit 31 free
      {1'b0, 16'd256,   15'd0,     15'd7936,  8'd32, 4'd5}, // R5 bit 31
      {1'b0, 16'd256,   15'd0,     15'd16384, 8'd64, 4'd5}, // R5 bit 32 kept
      {1'b1, 16'd300,   15'd0,     15'd0,     8'd0,  4'd2}, // R2 300 B -> 2 blocks
      {1'b0, 16'd512,   15'd0,     15'd0,     8'd1,  4'd2}  // R2 bits 0,1 free again
   };

   task automatic check(input bit ok, input int req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_alloc(input logic [15:0] size, input int exp_off,
                           input int exp_lat, input int req);
      int  lat = 0;
      bit  done = 1'b0;
      bit  ready_bad = 1'b0;
      @(negedge clk);
      req_valid = 1'b1;
      req_op    = 1'b0;
      req_size  = size;
      @(posedge clk);
      while (!done && lat < 200) begin
         @(negedge clk);
         req_valid = 1'b0;
         if (rsp_valid) done = 1'b1;
         else begin
            lat++;
            if (req_ready) ready_bad = 1'b1;
         end
      end
      check(done, req, "response seen", int'(done), 1);
      check(rsp_offset == 15'(exp_off), req, "offset", int'(rsp_offset), exp_off);
      check(lat == exp_lat, req, "latency", lat, exp_lat);
      check(!ready_bad, 7, "ready low during scan (R7)", int'(ready_bad), 0);
      check(req_ready, 7, "ready with response (R7)", int'(req_ready), 1);
      @(negedge clk);
      check(!rsp_valid, 7, "response pulse width (R7)", int'(rsp_valid), 0);
   endtask

   task automatic do_free(input logic [15:0] size, input logic [14:0] off, input int req);
      @(negedge clk);
      req_valid  = 1'b1;
      req_op     = 1'b1;
      req_size   = size;
      req_offset = off;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check(req_ready && !rsp_valid, req, "free takes one cycle, no response",
            int'({req_ready, rsp_valid}), 2);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(req_ready, 1, "ready in reset (R1)", int'(req_ready), 1);
      check(!rsp_valid, 1, "no response in reset (R1)", int'(rsp_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !rsp_valid, 1, "idle after reset (R1)",
            int'({req_ready, rsp_valid}), 2);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][58])
            do_free(VEC[i][57:42], VEC[i][41:27], int'(VEC[i][3:0]));
         else
            do_alloc(VEC[i][57:42], int'(VEC[i][26:12]), int'(VEC[i][11:4]),
                     int'(VEC[i][3:0]));
      end

      // R1: reset in mid-run empties the map
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(req_ready && !rsp_valid, 1, "idle in second reset (R1)",
            int'({req_ready, rsp_valid}), 2);
      rst_n = 1'b1;
      do_alloc(16'd8192, 0, 1, 1);      // R1 word 0 empty again
      do_alloc(16'd8192, 8192, 2, 1);   // R1 word 1 empty again
      do_alloc(16'd256, FAILV, 64, 6);  // R6 full map after two halves

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule